// File: doc/BRIEF.md
# I2C Byte-Stream Drain Target

This block is an I2C target through which a host empties an internal byte stream, for example the messages a receiver produces. The core pushes bytes into an internal FIFO. The host reaches the stream through a 256-entry register space. Only the top three entries respond. Two of them give the number of bytes waiting. The third hands out the next stream byte on each read, and drops that byte from the FIFO once it has been shifted out.

The SCL and SDA lines are sampled into the core clock domain. START and STOP are found from line edges. The block drives the bus only through open-drain enables, where a high enable pulls the line low. To set the register pointer, the host sends a write whose first data byte is the register number. A repeated START then turns the transfer into a read. Any STOP returns the pointer to the stream register, so a bare read always drains the stream. While a byte is being fetched, the block holds SCL low for one core cycle.

Top module: `i2c_stream_target`

## Requirements
- R1: The block answers, by pulling SDA low in the acknowledge slot, only an address byte whose upper seven bits equal `cfg_addr[7:1]` (`cfg_addr` 0x84 means target 0x42). Any other address gets no acknowledge, and the block leaves SDA released until the next START.
- R2: In a write transfer, the first data byte after the address loads the register pointer. Later data bytes are acknowledged and have no effect.
- R3: Each read of register 0xFF returns the oldest waiting FIFO byte, in push order.
- R4: A read of register 0xFF while the FIFO is empty returns 0xFF and removes nothing.
- R5: A read of register 0xFD returns bits 15:8 of the 16-bit pending count and stores the whole count as a snapshot. A read of register 0xFE returns bits 7:0 of the most recent snapshot, which is 0 after reset.
- R6: Reads of registers 0x00 to 0xFC return 0x00 and leave the FIFO unchanged.
- R7: After each byte read, the pointer advances by one and stops at 0xFF, so a long read drains the stream.
- R8: After reset and after every STOP, the pointer is 0xFF. A repeated START keeps the pointer that was written.
- R9: A stream byte leaves the FIFO once its eighth bit has been shifted out, whether the host acknowledges it or not. A NACK ends the read, and nothing more is removed.
- R10: When the FIFO holds FIFO_DEPTH bytes, `wr_full` is high and pushed bytes are discarded. The stored bytes are kept.
- R11: Before each read byte, the block holds SCL low (`scl_oe` high) for one core cycle while the byte is fetched.
- R12: After reset, `sda_oe`, `scl_oe` and `wr_full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| cfg_addr | input | 8 | Target address in bits 7:1, bit 0 unused |
| wr_valid | input | 1 | Push `wr_data` into the stream FIFO |
| wr_data | input | 8 | Stream byte to push |
| wr_full | output | 1 | FIFO holds FIFO_DEPTH bytes |

## Verification
Reads are tried in several forms:
- A bare read on an empty and on a filled FIFO shows the default pointer and the 0xFF filler.
- Reads that start at 0xFD, 0xFC and a reserved address show the count snapshot, the auto-increment and the saturation at 0xFF.
- A write with extra data bytes shows that only the first byte reaches the pointer.
- A single-byte read ended by a NACK shows that exactly one byte leaves the FIFO.

Overfilling the FIFO and then draining it shows that the dropped bytes are the new ones. A wrong address and then a changed `cfg_addr` show the address match.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_LOAD, ST_RDATA, ST_RACK
  } phase_t;

  localparam logic [7:0] REG_CNT_HI = 8'hFD;
  localparam logic [7:0] REG_CNT_LO = 8'hFE;
  localparam logic [7:0] REG_STREAM = 8'hFF;

  // pointer step that saturates on the stream register
  function automatic logic [7:0] next_ptr(input logic [7:0] p);
    return (p == REG_STREAM) ? REG_STREAM : p + 8'd1;
  endfunction

  function automatic logic addr_hit(input logic [7:0] cfg, input logic [7:0] rx);
    return cfg[7:1] == rx[7:1];
  endfunction

  // byte presented for a read of register p
  function automatic logic [7:0] reg_value(input logic [7:0] p, input logic [15:0] fill,
                                           input logic [15:0] snap, input logic empty,
                                           input logic [7:0] head);
    case (p)
      REG_CNT_HI: return fill[15:8];
      REG_CNT_LO: return snap[7:0];
      REG_STREAM: return empty ? 8'hFF : head;
      default:    return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cs_byte_fifo.sv
module i2cs_byte_fifo #(
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          pop,
  output logic [7:0]    dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wrap_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= wrap_inc(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R10
  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> count == $past(count)); // R10
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R4

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sda_s,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_evt,
  input  logic        stop_evt,
  input  logic [7:0]  cfg_addr,
  input  logic [15:0] fill,
  input  logic        fifo_empty,
  input  logic [7:0]  fifo_head,
  output logic        pop_evt,
  output logic        sda_oe,
  output logic        scl_oe
);
  phase_t      state;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg, ptr, load_byte;
  logic [15:0] snap;
  logic        rw, first_wr, from_stream, nack;

  assign load_byte = reg_value(ptr, fill, snap, fifo_empty, fifo_head);
  assign pop_evt   = (state == ST_RDATA) && scl_fall && (bitcnt == 4'd7) && from_stream;
  assign scl_oe    = (state == ST_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      ptr         <= REG_STREAM;
      snap        <= '0;
      rw          <= 1'b0;
      first_wr    <= 1'b0;
      from_stream <= 1'b0;
      nack        <= 1'b0;
      sda_oe      <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      ptr    <= REG_STREAM;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (state == ST_ADDR) begin
              if (addr_hit(cfg_addr, shreg)) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
                state  <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              state  <= ST_WACK;
              if (first_wr) begin
                ptr      <= shreg;
                first_wr <= 1'b0;
              end
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          sda_oe   <= 1'b0;
          bitcnt   <= '0;
          first_wr <= 1'b1;
          state    <= rw ? ST_LOAD : ST_WDATA;
        end
        ST_WACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
          state  <= ST_WDATA;
        end
        ST_LOAD: begin
          shreg       <= load_byte;
          sda_oe      <= ~load_byte[7];
          from_stream <= (ptr == REG_STREAM) && !fifo_empty;
          if (ptr == REG_CNT_HI) snap <= fill;
          bitcnt      <= '0;
          state       <= ST_RDATA;
        end
        ST_RDATA: if (scl_fall) begin
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7) begin
            sda_oe <= 1'b0;
            ptr    <= next_ptr(ptr);
            state  <= ST_RACK;
          end else begin
            shreg  <= {shreg[6:0], 1'b0};
            sda_oe <= ~shreg[6];
          end
        end
        ST_RACK: begin
          if (scl_rise) nack <= sda_s;
          else if (scl_fall) state <= nack ? ST_IDLE : ST_LOAD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R1
  AST_STOP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> ptr == REG_STREAM); // R8
  AST_POP_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> state == ST_RACK); // R9
  AST_STRETCH_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |=> !scl_oe); // R11

endmodule

// File: rtl/i2c_stream_target.sv
module i2c_stream_target #(
  parameter int FIFO_DEPTH  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [7:0] cfg_addr,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_full
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic          sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic          pop_evt, fifo_empty;
  logic [7:0]    fifo_head;
  logic [CW-1:0] fifo_count;
  logic [15:0]   fill;

  assign fill = 16'(fifo_count);

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cs_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_valid), .din(wr_data),
    .pop(pop_evt), .dout(fifo_head), .full(wr_full),
    .empty(fifo_empty), .count(fifo_count)
  );

  i2cs_engine u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .cfg_addr(cfg_addr), .fill(fill), .fifo_empty(fifo_empty),
    .fifo_head(fifo_head), .pop_evt(pop_evt), .sda_oe(sda_oe), .scl_oe(scl_oe)
  );

endmodule

// File: tb/sim_i2c_stream_target.sv
`timescale 1ns/1ps
module sim_i2c_stream_target;
  localparam int D = 8;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic scl_oe, sda_oe, wr_valid = 1'b0, wr_full;
  logic [7:0] wr_data = '0, cfg_addr = 8'h84;
  wire scl_bus = scl_h & ~scl_oe;
  wire sda_bus = sda_h & ~sda_oe;

  int errors = 0, checks = 0;
  bit busy = 1'b1, stretch_seen = 1'b0;
  logic [7:0] q[$];
  logic [7:0] mptr = 8'hFF;
  logic [15:0] msnap = '0;
  logic [6:0] addr7 = 7'h42;

  always #10 clk = ~clk;

  i2c_stream_target #(.FIFO_DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_addr(cfg_addr),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_full(wr_full)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model of the FIFO fill, compared every clock while the bus is quiet
  always @(posedge clk) if (rst_n && wr_valid && q.size() < D) q.push_back(wr_data);
  always @(negedge clk) begin
    if (scl_oe) stretch_seen = 1'b1;
    if (rst_n && !busy) check("R10 full flag", 16'(wr_full), 16'(q.size() == D));
  end

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic h_start;
    sda_h = 1'b1; waitn(Q);
    scl_h = 1'b1; wait (scl_bus); waitn(Q);
    sda_h = 1'b0; waitn(Q);
    scl_h = 1'b0; waitn(Q);
  endtask

  task automatic h_stop;
    sda_h = 1'b0; waitn(Q);
    scl_h = 1'b1; wait (scl_bus); waitn(Q);
    sda_h = 1'b1; waitn(2 * Q);
  endtask

  task automatic h_bit_tx(input logic b);
    sda_h = b; waitn(Q);
    scl_h = 1'b1; wait (scl_bus); waitn(Q);
    scl_h = 1'b0; waitn(Q);
  endtask

  task automatic h_bit_rx(output logic b);
    sda_h = 1'b1; waitn(Q);
    scl_h = 1'b1; wait (scl_bus); waitn(Q);
    b = sda_bus;
    scl_h = 1'b0; waitn(Q);
  endtask

  task automatic h_wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) h_bit_tx(v[i]);
    h_bit_rx(b);
    ack = ~b;
  endtask

  task automatic h_rbyte(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      h_bit_rx(b);
      v[i] = b;
    end
    h_bit_tx(~ack);
  endtask

  function automatic logic [7:0] model_byte();
    logic [7:0] r;
    case (mptr)
      8'hFD: begin msnap = 16'(q.size()); r = msnap[15:8]; end
      8'hFE: r = msnap[7:0];
      8'hFF: r = (q.size() != 0) ? q.pop_front() : 8'hFF;
      default: r = 8'h00;
    endcase
    mptr = (mptr == 8'hFF) ? 8'hFF : mptr + 8'd1;
    return r;
  endfunction

  task automatic xfer_read(input bit use_ptr, input logic [7:0] p, input int n, input string req);
    logic ack;
    logic [7:0] v;
    busy = 1'b1;
    h_start;
    if (use_ptr) begin
      h_wbyte({addr7, 1'b0}, ack);
      check({req, " R1 write addr ack"}, 16'(ack), 16'd1);
      h_wbyte(p, ack);
      mptr = p;
      h_start; // repeated START keeps pointer (R8)
    end
    h_wbyte({addr7, 1'b1}, ack);
    check({req, " R1 read addr ack"}, 16'(ack), 16'd1);
    for (int i = 0; i < n; i++) begin
      h_rbyte(v, i != n - 1);
      check(req, 16'(v), 16'(model_byte()));
    end
    h_stop;
    mptr = 8'hFF;
    waitn(4);
    busy = 1'b0;
  endtask

  task automatic push_bytes(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1; wr_data = base + 8'(i);
      waitn(1);
    end
    wr_valid = 1'b0;
    waitn(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] v;
    waitn(5);
    check("R12 sda_oe reset", 16'(sda_oe), 16'd0);
    check("R12 scl_oe reset", 16'(scl_oe), 16'd0);
    check("R12 wr_full reset", 16'(wr_full), 16'd0);
    rst_n = 1'b1;
    waitn(5);
    busy = 1'b0;

    xfer_read(1'b0, 8'h00, 2, "R4 R8 empty default read");
    push_bytes(3, 8'hA1);
    xfer_read(1'b0, 8'h00, 2, "R3 stream order");
    xfer_read(1'b1, 8'hFD, 4, "R5 R7 count then stream");
    push_bytes(2, 8'h31);
    xfer_read(1'b1, 8'h10, 2, "R6 reserved reads");
    xfer_read(1'b1, 8'hFC, 3, "R7 increment across count regs");

    // R2: extra write bytes ignored, pointer from first byte only
    busy = 1'b1;
    h_start;
    h_wbyte({addr7, 1'b0}, ack);
    h_wbyte(8'hFE, ack);
    check("R2 first data ack", 16'(ack), 16'd1);
    h_wbyte(8'h10, ack);
    check("R2 extra data ack", 16'(ack), 16'd1);
    h_wbyte(8'h20, ack);
    mptr = 8'hFE;
    h_start;
    h_wbyte({addr7, 1'b1}, ack);
    h_rbyte(v, 1'b0);
    check("R2 pointer from first byte", 16'(v), 16'(model_byte()));
    h_stop;
    mptr = 8'hFF;
    waitn(4);
    busy = 1'b0;

    // R1: wrong address ignored, then a new configured address
    busy = 1'b1;
    h_start;
    h_wbyte({7'h44, 1'b1}, ack);
    check("R1 no ack on mismatch", 16'(ack), 16'd0);
    h_stop;
    waitn(4);
    busy = 1'b0;
    xfer_read(1'b1, 8'hFD, 2, "R1 R6 count unchanged after mismatch");
    cfg_addr = 8'h50;
    addr7 = 7'h28;
    xfer_read(1'b0, 8'h00, 1, "R1 new address");

    // R9: NACKed byte popped, nothing more
    push_bytes(3, 8'hD1);
    xfer_read(1'b0, 8'h00, 1, "R9 nack single byte");
    xfer_read(1'b1, 8'hFD, 2, "R9 count after nack");
    xfer_read(1'b0, 8'h00, 3, "R9 remaining bytes");

    // R10: overfill drops newest bytes
    push_bytes(D + 3, 8'h60);
    check("R10 wr_full when full", 16'(wr_full), 16'd1);
    xfer_read(1'b0, 8'h00, D + 1, "R10 kept bytes then filler");
    check("R11 clock stretch seen", 16'(stretch_seen), 16'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule